// File: doc/BRIEF.md
# Attribute-Aware Write-Combining Store Buffer

This block sits between a processor store port and a memory write bus. The processor hands it one store per cycle through a valid/ready handshake and carries on at once. The buffer then drains the held stores to the bus in the background, one bus write per entry, strictly from oldest to youngest. The input is stalled only when every entry is occupied.

Every store carries a memory-type bit. Plain uncached stores that land in the same aligned 64-bit quadword may be folded into a single entry. Byte strobes are ORed together, and newer bytes replace older ones. A fold only ever targets the youngest entry, and only while that entry is still waiting behind another one. An entry that is already being offered on the bus is frozen. Device stores, meant for side-effecting registers, always take an entry of their own and are never folded. Because folding only reaches the youngest entry, a device store also shields everything older than itself. When nothing is held, an idle flag is raised so that later uncached loads can be fenced behind all earlier stores.

Store data and strobes arrive already lane-positioned within the quadword. The three low address bits are ignored, and the bus address is always quadword aligned.

Top module: `wcb_top`

## Requirements
- R1: After reset, bw_valid is 0, st_ready is 1 and idle is 1.
- R2: A store is taken on a clock edge where st_valid and st_ready are both 1. st_ready is 0 exactly when DEPTH (default 8) entries are held, and a store offered while full is not taken until an entry drains.
- R3: Bus writes leave in the order their entries were allocated, one write per entry, popped on a clock edge with bw_valid and bw_ready both 1. While bw_valid is 1 and bw_ready is 0, bw_addr, bw_data and bw_strb hold steady.
- R4: A plain store (st_device=0) whose quadword address (st_addr bits above bit 2) equals that of the youngest entry is folded into it, provided that entry is plain and is not the one on the bus. The result has strobe old|new, and each byte lane i takes the new byte where new strobe bit i is 1 and keeps the old byte otherwise.
- R5: A device store (st_device=1) always gets its own entry and produces its own bus write carrying exactly its own strobes.
- R6: A plain store is not folded into a youngest entry that is a device entry, nor into one with a different quadword address.
- R7: The entry currently offered on the bus (the oldest) is never modified. A plain store to its quadword allocates a new entry.
- R8: idle is 1 exactly when no entry is held, and bw_valid equals the inverse of idle.
- R9: bw_addr carries the entry's quadword address with its three low bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Buffer can take a store |
| st_addr | input | ADDR_W (32) | Store byte address; low 3 bits ignored |
| st_data | input | 64 | Lane-positioned store data |
| st_strb | input | 8 | Byte strobes, bit i enables lane i |
| st_device | input | 1 | 1 = device store (never folded), 0 = plain uncached |
| bw_valid | output | 1 | Bus write offered |
| bw_ready | input | 1 | Bus accepts the write |
| bw_addr | output | ADDR_W (32) | Quadword-aligned write address |
| bw_data | output | 64 | Write data |
| bw_strb | output | 8 | Write byte strobes |
| idle | output | 1 | No stores held (fence point) |

## Verification
The assertions take for granted that a store offer stays put while it is not yet taken, and that every store carries at least one strobe bit. Under those conditions, the stability, no-overflow and fold-target properties describe the buffer alone. The bench changes inputs only on falling edges, holds each store until st_ready allows it, and uses only non-zero strobe patterns. It sweeps pairs of overlapping strobe patterns over every combination of memory type, address match and head-of-queue position, and it fills the buffer to its full depth to exercise the stall.

// File: rtl/wcb_pkg.sv
package wcb_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 64;
    localparam int LANES  = DATA_W / 8;
    localparam int OFF_W  = $clog2(LANES);
    localparam int QA_W   = ADDR_W - OFF_W;

    typedef enum logic {
        MT_PLAIN  = 1'b0,
        MT_DEVICE = 1'b1
    } mtype_e;

    typedef struct packed {
        logic [QA_W-1:0]   qaddr;
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  strb;
        mtype_e            mtype;
    } wcb_entry_t;

    // Fold a newer store into an older entry: newer lanes win, strobes OR.
    function automatic wcb_entry_t fold_entry(wcb_entry_t older, wcb_entry_t newer);
        wcb_entry_t res;
        res = older;
        for (int i = 0; i < LANES; i++) begin
            if (newer.strb[i]) begin
                res.data[i*8 +: 8] = newer.data[i*8 +: 8];
            end
        end
        res.strb = older.strb | newer.strb;
        return res;
    endfunction

endpackage

// File: rtl/wcb_merge_ctl.sv
module wcb_merge_ctl
    import wcb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             take,
    input  wcb_entry_t       in_ent,
    input  wcb_entry_t       young_ent,
    input  logic [CNT_W-1:0] count,
    output logic             merge_en,
    output logic             alloc_en
);

    logic young_waiting;
    logic same_quad;
    logic both_plain;

    // The youngest entry is still waiting only if it is not the head,
    // since the head is offered on the bus as soon as it exists.
    assign young_waiting = (count >= CNT_W'(2));
    assign same_quad     = (young_ent.qaddr == in_ent.qaddr);
    assign both_plain    = (young_ent.mtype == MT_PLAIN) && (in_ent.mtype == MT_PLAIN);

    always_comb begin
        merge_en = take && young_waiting && same_quad && both_plain;
        alloc_en = take && !merge_en;
    end

endmodule

// File: rtl/wcb_queue.sv
module wcb_queue
    import wcb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc,
    input  logic             merge,
    input  logic             pop,
    input  wcb_entry_t       in_ent,
    output wcb_entry_t       head_ent,
    output wcb_entry_t       young_ent,
    output logic [CNT_W-1:0] count
);

    wcb_entry_t       slots [DEPTH];
    logic [PTR_W-1:0] head_ptr;
    logic [PTR_W-1:0] tail_ptr;
    logic [PTR_W-1:0] young_ptr;

    assign young_ptr = tail_ptr - PTR_W'(1);
    assign head_ent  = slots[head_ptr];
    assign young_ent = slots[young_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            head_ptr <= '0;
            tail_ptr <= '0;
            count    <= '0;
        end else begin
            if (alloc) tail_ptr <= tail_ptr + PTR_W'(1);
            if (pop)   head_ptr <= head_ptr + PTR_W'(1);
            count <= count + CNT_W'(alloc) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (alloc) begin
            slots[tail_ptr] <= in_ent;
        end else if (merge) begin
            slots[young_ptr] <= fold_entry(slots[young_ptr], in_ent);
        end
    end

    // R2: never allocate into a full queue unless a slot frees the same cycle
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        (alloc && !pop) |-> (count != CNT_W'(DEPTH)));

    // R3: never pop an empty queue
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count != '0));

    // R7: a fold never lands in the entry that sits on the bus
    p_merge_not_head_r7: assert property (@(posedge clk) disable iff (rst)
        merge |-> (young_ptr != head_ptr));

    // R6: folds only join plain stores of the same quadword
    p_merge_plain_r6: assert property (@(posedge clk) disable iff (rst)
        merge |-> (young_ent.mtype == MT_PLAIN && in_ent.mtype == MT_PLAIN
                   && young_ent.qaddr == in_ent.qaddr));

endmodule

// File: rtl/wcb_top.sv
module wcb_top
    import wcb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [LANES-1:0]  st_strb,
    input  logic              st_device,
    output logic              bw_valid,
    input  logic              bw_ready,
    output logic [ADDR_W-1:0] bw_addr,
    output logic [DATA_W-1:0] bw_data,
    output logic [LANES-1:0]  bw_strb,
    output logic              idle
);

    wcb_entry_t       in_ent;
    wcb_entry_t       head_ent;
    wcb_entry_t       young_ent;
    logic [CNT_W-1:0] count;
    logic             take;
    logic             pop;
    logic             merge_en;
    logic             alloc_en;

    always_comb begin
        in_ent.qaddr = st_addr[ADDR_W-1:OFF_W];
        in_ent.data  = st_data;
        in_ent.strb  = st_strb;
        in_ent.mtype = st_device ? MT_DEVICE : MT_PLAIN;
    end

    assign st_ready = (count != CNT_W'(DEPTH));
    assign take     = st_valid && st_ready;
    assign bw_valid = (count != '0);
    assign pop      = bw_valid && bw_ready;
    assign idle     = (count == '0);
    assign bw_addr  = {head_ent.qaddr, {OFF_W{1'b0}}};
    assign bw_data  = head_ent.data;
    assign bw_strb  = head_ent.strb;

    wcb_merge_ctl #(.DEPTH(DEPTH)) u_merge (
        .take      (take),
        .in_ent    (in_ent),
        .young_ent (young_ent),
        .count     (count),
        .merge_en  (merge_en),
        .alloc_en  (alloc_en)
    );

    wcb_queue #(.DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .alloc     (alloc_en),
        .merge     (merge_en),
        .pop       (pop),
        .in_ent    (in_ent),
        .head_ent  (head_ent),
        .young_ent (young_ent),
        .count     (count)
    );

    // R3: an offered write stays unchanged until the bus takes it
    p_hold_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (bw_valid && !bw_ready) |=> (bw_valid && $stable(bw_addr)
                                     && $stable(bw_data) && $stable(bw_strb)));

    // R5: a device store always grows the occupancy by one entry
    p_device_alloc_r5: assert property (@(posedge clk) disable iff (rst)
        (take && st_device) |=> (count == $past(count) + CNT_W'(1) - CNT_W'($past(pop))));

    // R8: with no store taken, an idle buffer stays idle
    p_idle_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (idle && !take) |=> (idle && !bw_valid));

    // R1: reset leaves the buffer empty
    p_reset_empty_r1: assert property (@(posedge clk)
        rst |=> (idle && st_ready && !bw_valid));

endmodule

// File: tb/test_wcb_top.sv
module test_wcb_top;
    import wcb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              st_valid;
    logic              st_ready;
    logic [ADDR_W-1:0] st_addr;
    logic [DATA_W-1:0] st_data;
    logic [LANES-1:0]  st_strb;
    logic              st_device;
    logic              bw_valid;
    logic              bw_ready;
    logic [ADDR_W-1:0] bw_addr;
    logic [DATA_W-1:0] bw_data;
    logic [LANES-1:0]  bw_strb;
    logic              idle;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wcb_top #(.DEPTH(DEPTH)) i_wcb_top (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_data(st_data), .st_strb(st_strb), .st_device(st_device),
        .bw_valid(bw_valid), .bw_ready(bw_ready), .bw_addr(bw_addr),
        .bw_data(bw_data), .bw_strb(bw_strb), .idle(idle)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] s);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < LANES; i++) m[i*8 +: 8] = {8{s[i]}};
        return m;
    endfunction

    // Called at a falling edge; returns at the falling edge after acceptance.
    task automatic push(input logic [QA_W-1:0] qa, input logic [DATA_W-1:0] d,
                        input logic [LANES-1:0] s, input logic dev);
        st_valid  = 1'b1;
        st_addr   = {qa, 3'b101};
        st_data   = d;
        st_strb   = s;
        st_device = dev;
        while (!st_ready) @(negedge clk);
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic expect_write(input logic [QA_W-1:0] qa, input logic [DATA_W-1:0] d,
                                input logic [LANES-1:0] s, input string req);
        int waited;
        waited = 0;
        while (!bw_valid && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        chk(bw_valid == 1'b1, req, "bw_valid", 64'(bw_valid), 64'd1);
        chk(bw_addr == {qa, 3'b000}, req, "bw_addr", 64'(bw_addr), 64'({qa, 3'b000}));
        chk(bw_strb == s, req, "bw_strb", 64'(bw_strb), 64'(s));
        chk((bw_data & lane_mask(s)) == (d & lane_mask(s)), req, "bw_data",
            bw_data & lane_mask(s), d & lane_mask(s));
        bw_ready = 1'b1;
        @(negedge clk);
        bw_ready = 1'b0;
    endtask

    localparam logic [DATA_W-1:0] D_A = 64'h1716151413121110;
    localparam logic [DATA_W-1:0] D_B = 64'h8786858483828180;
    localparam logic [DATA_W-1:0] D_F = 64'hF7F6F5F4F3F2F1F0;

    // kind 0: fold (R4), 1: B device (R5), 2: A device (R6),
    // 3: different quadword (R6), 4: all on head quadword (R7)
    task automatic run_pair(input int kind, input logic [LANES-1:0] a, input logic [LANES-1:0] b);
        logic [QA_W-1:0]   qf, qa, qb;
        logic [DATA_W-1:0] dm;
        bit                folds;
        string             req;
        qf = (kind == 4) ? QA_W'('h41) : QA_W'('h40);
        qa = QA_W'('h41);
        qb = (kind == 3) ? QA_W'('h42) : QA_W'('h41);
        folds = (kind == 0) || (kind == 4);
        case (kind)
            0: req = "R4";
            1: req = "R5";
            2: req = "R6";
            3: req = "R6";
            default: req = "R7";
        endcase
        push(qf, D_F, 8'hFF, 1'b0);
        push(qa, D_A, a, kind == 2);
        push(qb, D_B, b, kind == 1);
        expect_write(qf, D_F, 8'hFF, req);
        if (folds) begin
            for (int i = 0; i < LANES; i++)
                dm[i*8 +: 8] = b[i] ? D_B[i*8 +: 8] : D_A[i*8 +: 8];
            expect_write(qa, dm, a | b, req);
        end else begin
            expect_write(qa, D_A, a, req);
            expect_write(qb, D_B, b, req);
        end
        chk(idle == 1'b1 && bw_valid == 1'b0, "R8", "idle after drain",
            64'({idle, bw_valid}), 64'b10);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [LANES-1:0] pats [6];
        logic [ADDR_W-1:0] held_addr;
        pats[0] = 8'h01; pats[1] = 8'h0F; pats[2] = 8'hF0;
        pats[3] = 8'h3C; pats[4] = 8'hFF; pats[5] = 8'h80;
        rst = 1'b1; st_valid = 1'b0; st_addr = '0; st_data = '0;
        st_strb = '0; st_device = 1'b0; bw_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 / R8: reset state
        chk(bw_valid == 1'b0, "R1", "bw_valid after reset", 64'(bw_valid), 64'd0);
        chk(st_ready == 1'b1, "R1", "st_ready after reset", 64'(st_ready), 64'd1);
        chk(idle == 1'b1, "R1", "idle after reset", 64'(idle), 64'd1);

        // R4..R7: sweep strobe pairs over every kind
        for (int k = 0; k < 5; k++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    run_pair(k, pats[i], pats[j]);

        // R2 / R3 / R9: fill to depth, stall, stability, order
        for (int k = 0; k < DEPTH; k++)
            push(QA_W'('h100 + k), {8{8'(k + 1)}}, 8'hFF, k[0]);
        chk(st_ready == 1'b0, "R2", "st_ready when full", 64'(st_ready), 64'd0);
        chk(idle == 1'b0 && bw_valid == 1'b1, "R8", "busy when full",
            64'({idle, bw_valid}), 64'b01);
        held_addr = bw_addr;
        repeat (3) @(negedge clk);
        chk(bw_addr == held_addr, "R3", "held bw_addr", 64'(bw_addr), 64'(held_addr));
        chk(bw_addr[2:0] == 3'b000, "R9", "aligned bw_addr", 64'(bw_addr[2:0]), 64'd0);
        st_valid = 1'b1; st_addr = {QA_W'('h1FF), 3'b010};
        st_data = {8{8'h99}}; st_strb = 8'h3C; st_device = 1'b0;
        repeat (2) @(negedge clk);
        chk(st_ready == 1'b0, "R2", "stall holds", 64'(st_ready), 64'd0);
        expect_write(QA_W'('h100), {8{8'd1}}, 8'hFF, "R3");
        chk(st_ready == 1'b1, "R2", "ready after drain", 64'(st_ready), 64'd1);
        @(negedge clk);
        st_valid = 1'b0;
        for (int k = 1; k < DEPTH; k++)
            expect_write(QA_W'('h100 + k), {8{8'(k + 1)}}, 8'hFF, "R3");
        expect_write(QA_W'('h1FF), {8{8'h99}}, 8'h3C, "R2");
        chk(idle == 1'b1, "R8", "idle at end", 64'(idle), 64'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule